// File: doc/BRIEF.md
# Script-driven block-move DMA sequencer

This block is a small bus-master engine that runs a list of two-word instructions held in system memory. The host writes a start address into the script pointer. The engine then fetches each instruction over its bus-master port and decodes it. Block-move instructions are carried out as a series of bursts between memory and a data FIFO, so a whole scatter/gather list is processed without the host stepping in. An interrupt-type instruction, or an opcode the engine does not recognise, stops execution and raises the host interrupt.

Each data burst waits on the FIFO fill level. A send needs enough free room for the next burst. A receive needs enough stored bytes for it. Only then is the bus requested. Bursts are at most the configured burst size. The last burst of a move is cut down to whatever count remains. The FIFO, the device-side data path and any other opcodes are outside this block.

Top module: `sgdma_seq`

## Requirements
- R1: After reset the engine is idle. `bm_req`, `host_irq` and `host_err_illegal` are all 0.
- R2: A pointer write while idle starts a fetch on the next cycle. The fetch is an 8-byte memory read at the written address, with `bm_ifetch`=1, `bm_len`=8 and `bm_wr`=0. The first returned word is word 0 and the second is word 1.
- R3: Opcode word0[31:24] of 8'h00 or 8'h01 is a block move. Opcode bit 0 (word0[24]) = 1 means send toward the device, which is a memory read with `bm_wr`=0. Bit 0 = 0 means receive, which is a memory write with `bm_wr`=1. word0[23:0] is the byte count and word1 is the starting memory address.
- R4: Each data burst has length min(remaining count, `cfg_burst`). After each burst the address advances by that length and the count drops by it.
- R5: Before a send burst the engine waits until FIFO_BYTES − `fifo_level` ≥ the burst length. Before a receive burst it waits until `fifo_level` ≥ the burst length. It raises no data request while waiting.
- R6: When a move's count reaches zero, the next instruction is fetched from the script pointer plus 8, with no host action.
- R7: A block move with a count of zero issues no data burst and goes straight to the next fetch.
- R8: Opcode 8'h98 raises `host_irq`, and no further bus request is made while it is high.
- R9: Any other opcode raises `host_irq` and sets `host_err_illegal`.
- R10: Driving `host_irq_clr`=1 while halted clears `host_irq` and `host_err_illegal` on the next cycle. The engine then stays idle until the pointer is written again.
- R11: A pointer write while a script is running has no effect on the fetch order.
- R12: Once raised, a request holds its address, length and direction stable until `bm_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ptr_we | input | 1 | Script pointer write strobe |
| host_ptr_wdata | input | AW | Script start address |
| host_irq_clr | input | 1 | Write-1 clear of the interrupt status |
| host_irq | output | 1 | Host interrupt, high while halted |
| host_err_illegal | output | 1 | Illegal-opcode error flag |
| cfg_burst | input | LW | Programmed burst size in bytes (1..FIFO_BYTES) |
| fifo_level | input | LVL_W | Bytes currently held in the data FIFO |
| bm_req | output | 1 | Bus request, held until `bm_done` |
| bm_gnt | input | 1 | Bus grant |
| bm_addr | output | AW | Burst start address |
| bm_len | output | LW | Burst length in bytes |
| bm_wr | output | 1 | 1 = write to memory, 0 = read |
| bm_ifetch | output | 1 | Current request is an instruction fetch |
| bm_rdata | input | 32 | Read data returned for fetches |
| bm_rvalid | input | 1 | `bm_rdata` is valid for one beat |
| bm_done | input | 1 | Current burst has completed |

## Verification
The request for the first fetch is combinational from the state register. It is therefore sampled on the falling edge right after the pointer-write edge. The interrupt clear likewise takes effect one edge after the clear strobe and is sampled on the next falling edge. Burst and fetch results depend on how fast the bus model grants, so the bench logs every request the model accepts. It then polls `host_irq` once per cycle, with a bound, and compares the whole log against the expected list. For the FIFO gate, the bench holds the level out of range for a fixed 30 cycles, checks that no data request was logged, and only then opens the gate.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int ADDR_W      = 32;
  localparam int CNT_W       = 24;
  localparam int LEN_W       = 8;
  localparam int WORD_W      = 32;
  localparam int INSTR_BYTES = 8;

  localparam logic [7:0] OP_MOVE_RX = 8'h00;
  localparam logic [7:0] OP_MOVE_TX = 8'h01;
  localparam logic [7:0] OP_INTR    = 8'h98;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_WAIT, ST_XFER, ST_HALT
  } seq_state_e;

  typedef enum logic [1:0] {OPK_MOVE, OPK_INT, OPK_BAD} op_kind_e;

  function automatic op_kind_e classify(input logic [7:0] op);
    if (op == OP_MOVE_RX || op == OP_MOVE_TX) return OPK_MOVE;
    if (op == OP_INTR) return OPK_INT;
    return OPK_BAD;
  endfunction

  // length of the next burst: the programmed size, or the remainder if smaller
  function automatic logic [LEN_W-1:0] next_chunk(input logic [CNT_W-1:0] remain,
                                                  input logic [LEN_W-1:0] burst);
    if (remain < CNT_W'(burst)) return remain[LEN_W-1:0];
    return burst;
  endfunction

  // FIFO gate: room for a send, or enough stored bytes for a receive
  function automatic logic fifo_ready(input logic send, input int unsigned level,
                                      input int unsigned depth, input int unsigned need);
    if (level > depth) return 1'b0;
    if (send) return (depth - level) >= need;
    return level >= need;
  endfunction
endpackage

// File: rtl/sgdma_ptr.sv
module sgdma_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (adv)  ptr <= ptr + AW'(STEP);
  end
endmodule

// File: rtl/sgdma_mover.sv
module sgdma_mover
  import sgdma_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  input  logic [AW-1:0] load_addr,
  input  logic [LW-1:0] burst,
  input  logic          step,
  output logic [CW-1:0] remain,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] chunk,
  output logic          last
);
  assign chunk = next_chunk(remain, burst);
  assign last  = (remain == CW'(chunk));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      addr   <= '0;
    end else if (load) begin
      remain <= load_cnt;
      addr   <= load_addr;
    end else if (step) begin
      remain <= remain - CW'(chunk);
      addr   <= addr + AW'(chunk);
    end
  end
endmodule

// File: rtl/sgdma_gate.sv
module sgdma_gate
  import sgdma_pkg::*;
#(
  parameter int FIFO_BYTES = 64,
  parameter int LVL_W      = 7,
  parameter int LW         = LEN_W
) (
  input  logic [LVL_W-1:0] level,
  input  logic [LW-1:0]    need,
  input  logic             send,
  output logic             ok
);
  assign ok = fifo_ready(send, 32'(level), 32'(FIFO_BYTES), 32'(need));
endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
  import sgdma_pkg::*;
#(
  parameter int  AW         = ADDR_W,
  parameter int  CW         = CNT_W,
  parameter int  LW         = LEN_W,
  parameter int  FIFO_BYTES = 64,
  localparam int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_ptr_we,
  input  logic [AW-1:0]    host_ptr_wdata,
  input  logic             host_irq_clr,
  output logic             host_irq,
  output logic             host_err_illegal,
  input  logic [LW-1:0]    cfg_burst,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             bm_req,
  input  logic             bm_gnt,
  output logic [AW-1:0]    bm_addr,
  output logic [LW-1:0]    bm_len,
  output logic             bm_wr,
  output logic             bm_ifetch,
  input  logic [31:0]      bm_rdata,
  input  logic             bm_rvalid,
  input  logic             bm_done
);
  seq_state_e    state, state_nx;
  logic [31:0]   w0, w1;
  logic          beat, owned, dir_send, err_q;
  logic [AW-1:0] ptr;
  logic [CW-1:0] mv_remain;
  logic [AW-1:0] mv_addr;
  logic [LW-1:0] mv_chunk;
  logic          mv_last, gate_ok;
  op_kind_e      kind;

  // named internal events
  logic bus_done, ev_start, ev_fetch_done, ev_burst_done;
  logic ev_move_load, ev_halt, ev_clear, zero_cnt;

  assign kind          = classify(w0[31:24]);
  assign zero_cnt      = (w0[CW-1:0] == '0);
  assign bus_done      = bm_done && (owned || bm_gnt);
  assign ev_start      = (state == ST_IDLE)   && host_ptr_we;
  assign ev_fetch_done = (state == ST_FETCH)  && bus_done;
  assign ev_burst_done = (state == ST_XFER)   && bus_done;
  assign ev_move_load  = (state == ST_DECODE) && (kind == OPK_MOVE);
  assign ev_halt       = (state == ST_DECODE) && (kind != OPK_MOVE);
  assign ev_clear      = (state == ST_HALT)   && host_irq_clr;

  sgdma_ptr #(.AW(AW), .STEP(INSTR_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ev_start), .load_val(host_ptr_wdata),
    .adv(ev_fetch_done), .ptr(ptr)
  );

  sgdma_mover #(.AW(AW), .CW(CW), .LW(LW)) u_mover (
    .clk(clk), .rst_n(rst_n), .load(ev_move_load), .load_cnt(w0[CW-1:0]),
    .load_addr(w1[AW-1:0]), .burst(cfg_burst), .step(ev_burst_done),
    .remain(mv_remain), .addr(mv_addr), .chunk(mv_chunk), .last(mv_last)
  );

  sgdma_gate #(.FIFO_BYTES(FIFO_BYTES), .LVL_W(LVL_W), .LW(LW)) u_gate (
    .level(fifo_level), .need(mv_chunk), .send(dir_send), .ok(gate_ok)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (ev_start) state_nx = ST_FETCH;
      ST_FETCH:  if (ev_fetch_done) state_nx = ST_DECODE;
      ST_DECODE: begin
        if (kind != OPK_MOVE) state_nx = ST_HALT;
        else if (zero_cnt)    state_nx = ST_FETCH;
        else                  state_nx = ST_WAIT;
      end
      ST_WAIT:   if (gate_ok) state_nx = ST_XFER;
      ST_XFER:   if (ev_burst_done) state_nx = mv_last ? ST_FETCH : ST_WAIT;
      ST_HALT:   if (host_irq_clr) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      w0       <= '0;
      w1       <= '0;
      beat     <= 1'b0;
      owned    <= 1'b0;
      dir_send <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state <= state_nx;
      if (bus_done)    owned <= 1'b0;
      else if (bm_gnt) owned <= 1'b1;
      if (state == ST_FETCH && bm_rvalid) begin
        if (!beat) w0 <= bm_rdata;
        else       w1 <= bm_rdata;
        beat <= ~beat;
      end
      if (ev_fetch_done) beat <= 1'b0;
      if (ev_move_load)  dir_send <= w0[24];
      if (ev_halt && kind == OPK_BAD) err_q <= 1'b1;
      else if (ev_clear)              err_q <= 1'b0;
    end
  end

  assign host_irq         = (state == ST_HALT);
  assign host_err_illegal = err_q;
  assign bm_ifetch        = (state == ST_FETCH);
  assign bm_req           = (state == ST_FETCH) || (state == ST_XFER);
  assign bm_addr          = bm_ifetch ? ptr : mv_addr;
  assign bm_len           = bm_ifetch ? LW'(INSTR_BYTES) : mv_chunk;
  assign bm_wr            = (state == ST_XFER) && !dir_send;
endmodule

// File: rtl/sgdma_seq_chk.sv
module sgdma_seq_chk #(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_irq,
  input logic          host_irq_clr,
  input logic          host_err_illegal,
  input logic          bm_req,
  input logic          bm_done,
  input logic [AW-1:0] bm_addr,
  input logic [LW-1:0] bm_len,
  input logic          bm_wr,
  input logic          bm_ifetch,
  input logic [LW-1:0] cfg_burst,
  input logic          gate_ok,
  input logic          ev_burst_done,
  input logic          mv_last,
  input logic          ev_move_load,
  input logic          zero_cnt
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req && !bm_done |=> bm_req && $stable(bm_addr) && $stable(bm_len) && $stable(bm_wr));

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req && !bm_ifetch |-> (bm_len != '0) && (bm_len <= cfg_burst));

  // R2
  fetch_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bm_ifetch |-> bm_req && (bm_len == LW'(8)) && !bm_wr);

  // R5
  fifo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bm_req) && !bm_ifetch |-> $past(gate_ok));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> !bm_req);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq && host_irq_clr |=> !host_irq && !host_err_illegal);

  // R9
  err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_err_illegal |-> host_irq);

  // R6
  chain_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_burst_done && mv_last |=> bm_ifetch);

  // R7
  zero_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_move_load && zero_cnt |=> bm_ifetch);
endmodule

bind sgdma_seq sgdma_seq_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_irq(host_irq), .host_irq_clr(host_irq_clr),
  .host_err_illegal(host_err_illegal), .bm_req(bm_req), .bm_done(bm_done),
  .bm_addr(bm_addr), .bm_len(bm_len), .bm_wr(bm_wr), .bm_ifetch(bm_ifetch),
  .cfg_burst(cfg_burst), .gate_ok(gate_ok), .ev_burst_done(ev_burst_done),
  .mv_last(mv_last), .ev_move_load(ev_move_load), .zero_cnt(zero_cnt)
);

// File: tb/sgdma_seq_bench.sv
module sgdma_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 8;
  localparam int FIFO_BYTES = 64;
  localparam int LVL_W = $clog2(FIFO_BYTES + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             host_ptr_we = 1'b0;
  logic [AW-1:0]    host_ptr_wdata = '0;
  logic             host_irq_clr = 1'b0;
  logic             host_irq, host_err_illegal;
  logic [LW-1:0]    cfg_burst = 8'd4;
  logic [LVL_W-1:0] fifo_level = '0;
  logic             bm_req, bm_wr, bm_ifetch;
  logic [AW-1:0]    bm_addr;
  logic [LW-1:0]    bm_len;
  logic             bm_gnt, bm_rvalid, bm_done;
  logic [31:0]      bm_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] mem [0:255];
  logic [31:0] log_addr [0:63];
  int          log_len  [0:63];
  logic        log_wr   [0:63];
  int          log_n;
  logic [31:0] f_addr   [0:63];
  int          f_n;
  logic        busy;
  int          bcnt;

  sgdma_seq #(.FIFO_BYTES(FIFO_BYTES)) u_sgdma_seq (
    .clk(clk), .rst_n(rst_n), .host_ptr_we(host_ptr_we), .host_ptr_wdata(host_ptr_wdata),
    .host_irq_clr(host_irq_clr), .host_irq(host_irq), .host_err_illegal(host_err_illegal),
    .cfg_burst(cfg_burst), .fifo_level(fifo_level), .bm_req(bm_req), .bm_gnt(bm_gnt),
    .bm_addr(bm_addr), .bm_len(bm_len), .bm_wr(bm_wr), .bm_ifetch(bm_ifetch),
    .bm_rdata(bm_rdata), .bm_rvalid(bm_rvalid), .bm_done(bm_done)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // bus model: grant, two read beats for a fetch, fixed two-cycle data burst
  always @(posedge clk) begin
    if (!rst_n) begin
      busy <= 0; bm_gnt <= 0; bm_rvalid <= 0; bm_done <= 0; bcnt <= 0;
      bm_rdata <= '0; log_n <= 0; f_n <= 0;
    end else begin
      bm_gnt <= 0; bm_rvalid <= 0; bm_done <= 0;
      if (!busy) begin
        if (bm_req && !bm_done) begin
          busy <= 1; bm_gnt <= 1; bcnt <= 0;
          if (bm_ifetch) begin
            f_addr[f_n % 64] <= bm_addr; f_n <= f_n + 1;
          end else begin
            log_addr[log_n % 64] <= bm_addr;
            log_len[log_n % 64]  <= int'(bm_len);
            log_wr[log_n % 64]   <= bm_wr;
            log_n <= log_n + 1;
          end
        end
      end else begin
        bcnt <= bcnt + 1;
        if (bm_ifetch) begin
          bm_rvalid <= 1;
          bm_rdata  <= mem[((bm_addr >> 2) + 32'(bcnt)) & 32'hFF];
        end
        if (bcnt == 1) begin bm_done <= 1; busy <= 0; end
      end
    end
  end

  task automatic check(input string rq, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic put_move(input int idx, input bit send, input int cnt, input logic [31:0] a);
    mem[idx]     = {7'b0, send, 24'(cnt)};
    mem[idx + 1] = a;
  endtask

  task automatic put_word(input int idx, input logic [31:0] w);
    mem[idx] = w; mem[idx + 1] = '0;
  endtask

  task automatic write_ptr(input logic [31:0] v);
    @(negedge clk); host_ptr_we = 1; host_ptr_wdata = v;
    @(negedge clk); host_ptr_we = 0;
  endtask

  task automatic wait_irq(input string rq);
    int n = 0;
    while (!host_irq && n < 2000) begin @(negedge clk); n++; end
    check(rq, "irq raised", host_irq, 1);
  endtask

  task automatic clear_irq(input string rq);
    @(negedge clk); host_irq_clr = 1;
    @(negedge clk); host_irq_clr = 0;
    check(rq, "irq cleared", host_irq, 0);
    check(rq, "error cleared", host_err_illegal, 0);
  endtask

  task automatic burst_is(input string rq, input int i, input logic [31:0] a, input int len, input bit wr);
    check(rq, $sformatf("burst %0d addr", i), log_addr[i % 64], a);
    check(rq, $sformatf("burst %0d len", i), log_len[i % 64], len);
    check(rq, $sformatf("burst %0d wr", i), log_wr[i % 64], wr);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "req", bm_req, 0);
    check("R1", "irq", host_irq, 0);
    check("R1", "err", host_err_illegal, 0);
  endtask

  task automatic t_scatter();
    int lb = log_n, fb = f_n;
    put_move(64, 1, 10, 32'h2000);
    put_move(66, 0, 8, 32'h3000);
    put_word(68, 32'h9800_0000);
    fifo_level = 7'd32; cfg_burst = 8'd4;
    write_ptr(32'h100);
    check("R2", "req next cycle", bm_req, 1);
    check("R2", "ifetch", bm_ifetch, 1);
    check("R2", "fetch addr", bm_addr, 32'h100);
    check("R2", "fetch len", bm_len, 8);
    wait_irq("R8");
    check("R4", "burst count", log_n - lb, 5);
    burst_is("R3", lb,     32'h2000, 4, 0);
    burst_is("R4", lb + 1, 32'h2004, 4, 0);
    burst_is("R4", lb + 2, 32'h2008, 2, 0);
    burst_is("R3", lb + 3, 32'h3000, 4, 1);
    burst_is("R4", lb + 4, 32'h3004, 4, 1);
    check("R6", "fetch count", f_n - fb, 3);
    check("R6", "fetch 1", f_addr[(fb + 1) % 64], 32'h108);
    check("R6", "fetch 2", f_addr[(fb + 2) % 64], 32'h110);
    repeat (10) @(negedge clk);
    check("R8", "no req while halted", bm_req, 0);
    check("R8", "no new fetch", f_n - fb, 3);
    clear_irq("R10");
  endtask

  task automatic t_gate();
    int lb = log_n, fb = f_n;
    put_move(128, 1, 4, 32'h4000);
    put_word(130, 32'h9800_0000);
    fifo_level = 7'd62;
    write_ptr(32'h200);
    repeat (30) @(negedge clk);
    check("R5", "send held on low room", log_n - lb, 0);
    write_ptr(32'h300);
    fifo_level = 7'd0;
    wait_irq("R5");
    check("R5", "send burst after room", log_n - lb, 1);
    burst_is("R5", lb, 32'h4000, 4, 0);
    check("R11", "fetch after running write", f_addr[(fb + 1) % 64], 32'h208);
    clear_irq("R10");
    lb = log_n;
    put_move(160, 0, 6, 32'h5000);
    put_word(162, 32'h9800_0000);
    fifo_level = 7'd3;
    write_ptr(32'h280);
    repeat (30) @(negedge clk);
    check("R5", "receive held on low fill", log_n - lb, 0);
    fifo_level = 7'd4;
    wait_irq("R5");
    check("R4", "receive bursts", log_n - lb, 2);
    burst_is("R5", lb,     32'h5000, 4, 1);
    burst_is("R4", lb + 1, 32'h5004, 2, 1);
    clear_irq("R10");
  endtask

  task automatic t_zero();
    int lb = log_n, fb = f_n;
    put_move(96, 1, 0, 32'h6000);
    put_word(98, 32'h9800_0000);
    fifo_level = 7'd32;
    write_ptr(32'h180);
    wait_irq("R7");
    check("R7", "no data burst", log_n - lb, 0);
    check("R7", "fetch count", f_n - fb, 2);
    check("R7", "second fetch", f_addr[(fb + 1) % 64], 32'h188);
    check("R8", "no error on interrupt op", host_err_illegal, 0);
    clear_irq("R10");
  endtask

  task automatic t_illegal();
    int fb = f_n;
    put_word(224, 32'h5500_0000);
    write_ptr(32'h380);
    wait_irq("R9");
    check("R9", "error flag", host_err_illegal, 1);
    check("R9", "single fetch", f_n - fb, 1);
    clear_irq("R10");
    repeat (20) @(negedge clk);
    check("R10", "idle no req", bm_req, 0);
    check("R10", "idle no fetch", f_n - fb, 1);
    write_ptr(32'h180);
    wait_irq("R10");
    check("R10", "restart fetches", f_n - fb, 3);
    clear_irq("R10");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_scatter();
    t_gate();
    t_zero();
    t_illegal();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule